// File: doc/BRIEF.md
# Zoned TLB Address Translator

The block looks up a virtual address in a fully associative table of translation entries and returns a registered result one clock after each request. Every entry carries three words. A tag word holds the effective page number, a valid flag and a page-size code. A data word holds the real page number, write and execute enables and a zone selector. The third word is an 8-bit translation ID. The table contents, the current process ID and a 32-bit zone protection word are inputs. The block does not load or maintain the table itself.

Each entry has its own page size, from 1 KB to 16 MB in steps of four. The zone protection word splits into sixteen 2-bit codes. Through its selector, an entry picks one code, and that code can hide the entry from user accesses or widen its write and execute rights. Entries are searched from index 0 upward. The first entry that qualifies decides the outcome: a hit with a physical address and the granted rights, or a protection fault. When no entry qualifies, the result is a miss.

Top module: `zoned_tlb_xlate`

## Requirements
- R1: While reset is asserted and after it, until the next request, rsp_valid is 0 and rsp_status, rsp_index, rsp_paddr and rsp_perm are all 0.
- R2: rsp_valid equals req_valid of the previous clock. The result fields carry the outcome of the request sampled at that clock edge.
- R3: Tag bits [9:7] are a size code c that selects a page of 1 KB times 4^c. Tag bit 6 is the valid flag. An entry matches only when it is valid and the virtual address equals the tag in every bit at or above bit 10+2c.
- R4: A translation ID of 0 matches any process ID. A nonzero translation ID matches only when it equals pid.
- R5: Data bits [7:4] give a zone selector z, and the zone code is zone_reg bits [31-2z:30-2z]. When z is greater than ZONE_COUNT (default 11), or when ZONES_ON is 0, the code is taken as 1.
- R6: With zone code 0, a user access (req_user=1) skips the entry and the search continues. A privileged access uses the entry's own rights. With code 1, every access uses the entry's own rights: data bit 8 is write and data bit 9 is execute.
- R7: Zone code 2 grants write and execute to privileged accesses only, and user accesses keep the entry's own rights. Zone code 3 grants write and execute to every access.
- R8: The lowest-index qualifying entry decides the result. When none qualifies, rsp_status is 0 (miss), and rsp_index, rsp_paddr and rsp_perm are 0.
- R9: req_kind encodes 0 read, 1 write and 2 fetch, and 3 acts as a read. Read right is always granted on a qualifying entry. A write without the write right, or a fetch without the execute right, gives rsp_status 1 (fault) with that entry's index, rsp_paddr 0 and its rights. No later entry is considered.
- R10: On a hit, rsp_status is 2, and rsp_index is the entry. rsp_paddr takes the bits at or above the page size from data bits [31:10] and the bits below it from the virtual address. rsp_perm is {execute, write, read}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user access, 0 for a privileged access |
| pid | input | 8 | Current process ID |
| zone_reg | input | 32 | Sixteen 2-bit zone codes, zone 0 in bits [31:30] |
| tag_words | input | 32*NUM_ENTRIES | Tag word of entry i in bits [32i+31:32i] |
| data_words | input | 32*NUM_ENTRIES | Data word of entry i in bits [32i+31:32i] |
| tid_words | input | 8*NUM_ENTRIES | Translation ID of entry i in bits [8i+7:8i] |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | 0 miss, 1 fault, 2 hit |
| rsp_index | output | log2(NUM_ENTRIES) | Deciding entry |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_perm | output | 3 | Granted rights {execute, write, read} |

## Verification
Every result, including rsp_valid, is due exactly one rising edge after the request is sampled. The bench drives a request on a falling edge and lets one rising edge register it. It reads the outputs on the following falling edge, before it drives the next request. An idle cycle follows, and in that cycle rsp_valid must fall to 0. Because each lookup is checked in the single cycle where its result is due, a result that arrives one cycle early or late shows up as a wrong value.

// File: rtl/zoned_tlb_xlate.sv
module zoned_tlb_xlate #(
  parameter int NUM_ENTRIES = 64,
  parameter int ZONE_COUNT  = 11,
  parameter bit ZONES_ON    = 1'b1,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [31:0]               req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_user,
  input  logic [7:0]                pid,
  input  logic [31:0]               zone_reg,
  input  logic [32*NUM_ENTRIES-1:0] tag_words,
  input  logic [32*NUM_ENTRIES-1:0] data_words,
  input  logic [8*NUM_ENTRIES-1:0]  tid_words,
  output logic                      rsp_valid,
  output logic [1:0]                rsp_status,
  output logic [IW-1:0]             rsp_index,
  output logic [31:0]               rsp_paddr,
  output logic [2:0]                rsp_perm
);

  localparam logic [1:0] ST_MISS  = 2'd0;
  localparam logic [1:0] ST_FAULT = 2'd1;
  localparam logic [1:0] ST_HIT   = 2'd2;
  localparam logic [1:0] K_WRITE  = 2'd1;
  localparam logic [1:0] K_FETCH  = 2'd2;

  logic [NUM_ENTRIES-1:0] cand, wr_ok, ex_ok;
  logic [31:0]            pa [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [31:0] tw, dw, lm;
    logic [7:0]  id;
    logic [4:0]  sh, zb;
    logic [3:0]  zs;
    logic [1:0]  zc;
    assign tw = tag_words[g*32 +: 32];
    assign dw = data_words[g*32 +: 32];
    assign id = tid_words[g*8 +: 8];
    assign sh = 5'd10 + {1'b0, tw[9:7], 1'b0};
    assign lm = (32'd1 << sh) - 32'd1;
    assign zs = dw[7:4];
    assign zb = 5'd31 - {zs, 1'b0};
    assign zc = (!ZONES_ON || (int'(zs) > ZONE_COUNT)) ? 2'd1 : zone_reg[zb -: 2];
    assign cand[g]  = tw[6] && (((req_vaddr ^ tw) & ~lm) == 32'd0)
                      && (id == 8'd0 || id == pid)
                      && !(zc == 2'd0 && req_user);
    assign wr_ok[g] = dw[8] || zc == 2'd3 || (zc == 2'd2 && !req_user);
    assign ex_ok[g] = dw[9] || zc == 2'd3 || (zc == 2'd2 && !req_user);
    assign pa[g]    = (dw & ~lm & 32'hFFFF_FC00) | (req_vaddr & lm);
  end

  logic          found;
  logic [IW-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  logic       s_wr, s_ex, fault;
  logic [1:0] nx_status;

  assign s_wr  = wr_ok[sel];
  assign s_ex  = ex_ok[sel];
  assign fault = (req_kind == K_WRITE && !s_wr) || (req_kind == K_FETCH && !s_ex);
  assign nx_status = !found ? ST_MISS : (fault ? ST_FAULT : ST_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_index  <= '0;
      rsp_paddr  <= '0;
      rsp_perm   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= nx_status;
        rsp_index  <= found ? sel : '0;
        rsp_paddr  <= (nx_status == ST_HIT) ? pa[sel] : 32'd0;
        rsp_perm   <= found ? {s_ex, s_wr, 1'b1} : 3'b000;
      end
    end
  end

endmodule

// File: rtl/zoned_tlb_xlate_checks.sv
module zoned_tlb_xlate_checks #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [IW-1:0] rsp_index,
  input logic [31:0]   rsp_paddr,
  input logic [2:0]    rsp_perm
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r8_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> (rsp_perm == 3'b000 && rsp_paddr == 32'd0 && rsp_index == '0));

  a_r9_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> rsp_perm[0]);

  a_r9_fault_reason: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |->
      (($past(req_kind) == 2'd1 && !rsp_perm[1]) || ($past(req_kind) == 2'd2 && !rsp_perm[2])));

  a_r10_hit_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd2) |->
      !(($past(req_kind) == 2'd1 && !rsp_perm[1]) || ($past(req_kind) == 2'd2 && !rsp_perm[2])));

  a_r9_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);

endmodule

bind zoned_tlb_xlate zoned_tlb_xlate_checks #(.IW(IW)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_index(rsp_index),
  .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
);

// File: tb/zoned_tlb_xlate_bench.sv
`timescale 1ns/1ps
module zoned_tlb_xlate_bench;
  localparam int N  = 64;
  localparam int IW = 6;
  localparam int ZC = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [7:0]  pid = '0;
  logic [31:0] zone_reg = '0;
  logic [32*N-1:0] tag_words, data_words;
  logic [8*N-1:0]  tid_words;
  logic            rsp_valid;
  logic [1:0]      rsp_status;
  logic [IW-1:0]   rsp_index;
  logic [31:0]     rsp_paddr;
  logic [2:0]      rsp_perm;

  logic [31:0] t_tag [N];
  logic [31:0] t_dat [N];
  logic [7:0]  t_tid [N];

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign tag_words[g*32 +: 32] = t_tag[g];
    assign data_words[g*32 +: 32] = t_dat[g];
    assign tid_words[g*8 +: 8] = t_tid[g];
  end

  zoned_tlb_xlate u_zoned_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .pid(pid), .zone_reg(zone_reg),
    .tag_words(tag_words), .data_words(data_words), .tid_words(tid_words),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_index(rsp_index),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] va, input logic [1:0] k, input logic u,
                       input logic [7:0] p, input logic [31:0] z,
                       output logic [1:0] st, output int idx,
                       output logic [31:0] pa, output logic [2:0] pm);
    st = 2'd0; idx = 0; pa = 0; pm = 0;
    for (int i = 0; i < N; i++) begin
      int bytes, zsel, code;
      logic w, x;
      bytes = 1024 << (2 * int'(t_tag[i][9:7]));
      if (!t_tag[i][6]) continue;
      if ((va / bytes) != (t_tag[i] / bytes)) continue;
      if (t_tid[i] != 0 && t_tid[i] != p) continue;
      zsel = int'(t_dat[i][7:4]);
      code = int'((z >> (30 - 2 * zsel)) & 32'd3);
      if (zsel > ZC) code = 1;
      if (code == 0 && u) continue;
      w = t_dat[i][8];
      x = t_dat[i][9];
      if (code == 3 || (code == 2 && !u)) begin w = 1; x = 1; end
      idx = i;
      pm = {x, w, 1'b1};
      if ((k == 2'd1 && !w) || (k == 2'd2 && !x)) begin
        st = 2'd1;
        return;
      end
      st = 2'd2;
      pa = ((t_dat[i] >> 10) << 10) / bytes * bytes + va % bytes;
      return;
    end
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] k,
                        input logic u, input logic [7:0] p, input logic [31:0] z,
                        input int es, input int ei);
    logic [1:0] st; int idx; logic [31:0] pa; logic [2:0] pm;
    @(negedge clk);
    req_vaddr = va; req_kind = k; req_user = u; pid = p; zone_reg = z; req_valid = 1'b1;
    model(va, k, u, p, z, st, idx, pa, pm);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R2 valid"}, 64'(rsp_valid), 64'd1);
    if (es >= 0) check({req, " status"}, 64'(rsp_status), 64'(es));
    if (ei >= 0) check({req, " index"}, 64'(rsp_index), 64'(ei));
    check({req, " model status"}, 64'(rsp_status), 64'(st));
    check({req, " model index"}, 64'(rsp_index), 64'(idx));
    check({req, " model paddr"}, 64'(rsp_paddr), 64'(pa));
    check({req, " model perm"}, 64'(rsp_perm), 64'(pm));
  endtask

  task automatic clear_tlb();
    for (int i = 0; i < N; i++) begin t_tag[i] = 0; t_dat[i] = 0; t_tid[i] = 0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] z01;
    clear_tlb();
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset status", 64'(rsp_status), 64'd0);
    check("R1 reset paddr", 64'(rsp_paddr), 64'd0);
    check("R1 reset perm", 64'(rsp_perm), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset idle", 64'(rsp_valid), 64'd0);

    lookup("R8 empty miss", 32'h1234_5678, 2'd0, 1'b0, 8'd0, 32'h0, 0, 0);

    z01 = 32'h5555_5555;
    t_tag[5] = 32'h1234_5400 | 32'h40;
    t_dat[5] = 32'hABCD_E000 | 32'h300;
    lookup("R10 1K hit", 32'h1234_57FF, 2'd0, 1'b0, 8'd0, z01, 2, 5);
    check("R10 1K paddr", 64'(rsp_paddr), 64'hABCD_E3FF);
    lookup("R3 1K neighbour miss", 32'h1234_5800, 2'd0, 1'b0, 8'd0, z01, 0, 0);
    t_tag[5] = 32'h1234_5400;
    lookup("R3 invalid miss", 32'h1234_57FF, 2'd0, 1'b0, 8'd0, z01, 0, 0);

    t_tag[7] = 32'h5600_0000 | 32'h40 | (32'd7 << 7);
    t_dat[7] = 32'h9A00_0000 | 32'h300;
    lookup("R3 16M hit", 32'h56AB_CDEF, 2'd2, 1'b1, 8'd0, z01, 2, 7);
    check("R10 16M paddr", 64'(rsp_paddr), 64'h9AAB_CDEF);
    lookup("R3 16M outside", 32'h5700_0000, 2'd0, 1'b0, 8'd0, z01, 0, 0);

    t_tid[7] = 8'h22;
    lookup("R4 tid mismatch", 32'h56AB_CDEF, 2'd0, 1'b0, 8'h21, z01, 0, 0);
    lookup("R4 tid match", 32'h56AB_CDEF, 2'd0, 1'b0, 8'h22, z01, 2, 7);
    t_tid[7] = 8'h00;
    lookup("R4 tid zero any pid", 32'h56AB_CDEF, 2'd0, 1'b0, 8'h99, z01, 2, 7);

    clear_tlb();
    t_tag[3] = 32'h0040_0000 | 32'h40 | (32'd2 << 7);
    t_dat[3] = 32'h0080_0000 | (32'd1 << 4);
    t_tag[9] = 32'h0040_0000 | 32'h40 | (32'd2 << 7);
    t_dat[9] = 32'h00C0_0000 | 32'h300;
    lookup("R8 lowest index wins", 32'h0040_1234, 2'd0, 1'b0, 8'd0, z01, 2, 3);
    lookup("R9 write fault stops search", 32'h0040_1234, 2'd1, 1'b0, 8'd0, z01, 1, 3);
    check("R9 fault paddr", 64'(rsp_paddr), 64'd0);
    lookup("R6 zone0 user skips", 32'h0040_1234, 2'd0, 1'b1, 8'd0, 32'h4000_0000, 2, 9);
    lookup("R6 zone0 priv uses entry", 32'h0040_1234, 2'd2, 1'b0, 8'd0, 32'h4000_0000, 1, 3);

    t_dat[3] = 32'h0080_0000 | (32'd2 << 4);
    lookup("R7 zone2 priv write", 32'h0040_1234, 2'd1, 1'b0, 8'd0, 32'h0800_0000, 2, 3);
    check("R7 zone2 priv perm", 64'(rsp_perm), 64'd7);
    lookup("R7 zone2 user write fault", 32'h0040_1234, 2'd1, 1'b1, 8'd0, 32'h0800_0000, 1, 3);
    lookup("R7 zone3 user fetch", 32'h0040_1234, 2'd2, 1'b1, 8'd0, 32'h0C00_0000, 2, 3);
    lookup("R9 kind3 acts as read", 32'h0040_1234, 2'd3, 1'b1, 8'd0, 32'h0800_0000, 2, 3);

    t_dat[3] = 32'h0080_0000 | (32'd13 << 4);
    lookup("R5 zone above count is code1", 32'h0040_1234, 2'd0, 1'b1, 8'd0, 32'h0, 2, 3);
    t_dat[3] = 32'h0080_0000 | (32'd11 << 4);
    t_tag[9] = 0;
    lookup("R5 zone at count uses field", 32'h0040_1234, 2'd0, 1'b1, 8'd0, 32'h0, 0, 0);
    lookup("R5 zone11 field code1", 32'h0040_1234, 2'd0, 1'b1, 8'd0, 32'h0000_0100, 2, 3);

    void'($urandom(32'd4242));
    for (int it = 0; it < 300; it++) begin
      int e; logic [31:0] va;
      if (it % 15 == 0) begin
        for (int i = 0; i < N; i++) begin
          t_tag[i] = ($urandom & 32'hFFFF_FC00) | (($urandom % 4 != 0) ? 32'h40 : 32'h0)
                     | (32'($urandom % 8) << 7);
          if ($urandom % 3 == 0) t_tag[i][31:24] = 8'h00;
          t_dat[i] = $urandom & 32'hFFFF_FFF0;
          t_tid[i] = ($urandom % 2 == 0) ? 8'd0 : 8'($urandom % 4);
        end
      end
      e = int'($urandom % N);
      va = (t_tag[e] & 32'hFFFF_FC00) ^ ($urandom & 32'h00FF_FFFF & ((32'd1 << ($urandom % 25)) - 1));
      lookup("R3 R6 R8 R10 random", va, 2'($urandom % 4), 1'($urandom), 8'($urandom % 4),
             $urandom, -1, -1);
    end

    @(negedge clk);
    check("R2 idle no valid", 64'(rsp_valid), 64'd0);
    finish_run();
  end
endmodule